// File: doc/BRIEF.md
# Event-Paced Peripheral Byte Mover

This block is a single channel that copies bytes between one fixed peripheral data-register address and a linear memory buffer. A serial peripheral paces the channel. Each "transmit side is empty" or "receive side holds a byte" pulse asks for one byte. For each request the channel carries out one beat. A beat is a read followed by a write on a simple single-beat bus master port. After each beat the remaining-byte count drops by one.

Software sets up the channel through a small register interface. It writes a peripheral address, one or two memory base addresses, a byte count and a control word. The control word holds the direction, the interrupt enables, the ping-pong mode and the run bit. When the count runs out, the channel sends a one-cycle end pulse back to the peripheral and latches a completion flag. In ping-pong mode the channel then swaps to the other buffer and keeps running. A second flag marks the moment the remaining count reaches half the programmed size.

Top module: `pdma_stream`

## Requirements
- R1: After reset, the following are all low: `m_req`, `xfer_end_o` and `irq`. A read of the control word (offset 0) returns 0, and a read of the flag word (offset 5) returns 0.
- R2: With the direction bit (control bit 1) set, each `tx_empty_req` pulse moves one byte. Beat k reads memory at base+k and writes the byte to the peripheral address (offset 2). `rx_full_req` pulses cause no bus activity in this direction.
- R3: With the direction bit clear, each `rx_full_req` pulse reads the peripheral address and writes the byte to memory at base+k. `tx_empty_req` pulses cause no bus activity in this direction.
- R4: While the run bit (control bit 0) is clear, request pulses start no bus access. While the run bit is set, writes to the byte count (offset 1), the peripheral address (offset 2) and the memory bases (offsets 3 and 4) are ignored.
- R5: Setting the run bit from 0 to 1 loads the remaining count (read at offset 6) with the programmed count. The remaining count then decrements by one per completed beat.
- R6: On the beat that brings the remaining count to zero, three things happen. `xfer_end_o` is high for exactly one cycle. The completion flag (flag bit 1) sets. Outside ping-pong mode the run bit clears by itself.
- R7: The half flag (flag bit 0) sets on the beat after which the remaining count equals the programmed count shifted right by one. It does not set on any earlier beat.
- R8: With ping-pong mode (control bit 4) set, a count-out does not stop the channel. It reloads the remaining count, flips the active-buffer bit (control bit 5, read only) and keeps the run bit set. The following beats address the base at offset 4, starting from offset 0.
- R9: A request that arrives while a beat is in flight is held pending and serviced later. A burst of back-to-back requests yields one beat per request.
- R10: Writing a one to a flag bit at offset 5 clears that flag. Writing a zero leaves it unchanged. A flag that sets in the same cycle stays set.
- R11: `irq` is high exactly when (half flag AND control bit 2) OR (completion flag AND control bit 3).
- R12: The bus master raises `m_req` and holds `m_req`, `m_addr` and `m_we` stable until `m_ack`. Every beat begins with a read access (`m_we` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| tx_empty_req | input | 1 | Peripheral transmit-side-empty request pulse |
| rx_full_req | input | 1 | Peripheral receive-side-full request pulse |
| xfer_end_o | output | 1 | One-cycle end-of-transfer pulse to the peripheral |
| irq | output | 1 | Interrupt, level |
| m_req | output | 1 | Bus access request |
| m_we | output | 1 | Bus access is a write |
| m_addr | output | ADDR_W | Bus byte address |
| m_wdata | output | 8 | Bus write data |
| m_rdata | input | 8 | Bus read data, valid with `m_ack` |
| m_ack | input | 1 | Bus access completes this cycle |

## Verification
A wrong count or offset register shows up at the bus within one beat. The byte goes to a shifted memory address, or the wrong byte goes to the peripheral. The remaining count read back at offset 6 also disagrees after the next beat. A lost pending request or a stuck pending count shows up later, when the transfer ends. The end pulse and the completion flag then fail to appear, or appear too early, and the run bit has not cleared. A fault in the half-mark compare or the buffer-swap logic is visible in the flag word and the active-buffer bit on the cycle after the beat that should have caused it.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;
  localparam int REG_AW = 3;

  // Register word offsets
  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 3'd0,
    RA_NBYTES = 3'd1,
    RA_PADDR  = 3'd2,
    RA_MBASE0 = 3'd3,
    RA_MBASE1 = 3'd4,
    RA_FLAGS  = 3'd5,
    RA_REMAIN = 3'd6
  } reg_sel_e;

  // Control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_HIE  = 2;
  localparam int CB_FIE  = 3;
  localparam int CB_DBUF = 4;

  // Flag word bit positions
  localparam int FB_HALF = 0;
  localparam int FB_FULL = 1;

  typedef struct packed {
    logic dbuf;
    logic fie;
    logic hie;
    logic dir;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    BT_IDLE  = 2'd0,
    BT_READ  = 2'd1,
    BT_WRITE = 2'd2
  } beat_st_e;
endpackage

// File: rtl/pdma_regs.sv
`timescale 1ns/1ps
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [CNT_W-1:0]  rem,
  input  logic              cur_buf,
  input  logic              half_hit,
  input  logic              xfer_end,
  output ctrl_t             ctrl,
  output logic              en_load,
  output logic [CNT_W-1:0]  prog_cnt,
  output logic [ADDR_W-1:0] paddr,
  output logic [ADDR_W-1:0] mbase0,
  output logic [ADDR_W-1:0] mbase1,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic              half_q, full_q;
  logic [CNT_W-1:0]  prog_q;
  logic [ADDR_W-1:0] paddr_q, mbase0_q, mbase1_q;

  logic wr_ctrl, wr_flags, cfg_open;
  assign wr_ctrl  = cfg_wr && (cfg_addr == RA_CTRL);
  assign wr_flags = cfg_wr && (cfg_addr == RA_FLAGS);
  assign cfg_open = !ctrl_q.en;
  assign en_load  = wr_ctrl && cfg_wdata[CB_EN] && !ctrl_q.en;

  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      half_q   <= 1'b0;
      full_q   <= 1'b0;
      prog_q   <= '0;
      paddr_q  <= '0;
      mbase0_q <= '0;
      mbase1_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en   <= cfg_wdata[CB_EN];
        ctrl_q.dir  <= cfg_wdata[CB_DIR];
        ctrl_q.hie  <= cfg_wdata[CB_HIE];
        ctrl_q.fie  <= cfg_wdata[CB_FIE];
        ctrl_q.dbuf <= cfg_wdata[CB_DBUF];
      end else if (xfer_end && !ctrl_q.dbuf) begin
        ctrl_q.en <= 1'b0;
      end
      if (cfg_open && cfg_wr) begin
        if (cfg_addr == RA_NBYTES) prog_q   <= cfg_wdata[CNT_W-1:0];
        if (cfg_addr == RA_PADDR)  paddr_q  <= cfg_wdata[ADDR_W-1:0];
        if (cfg_addr == RA_MBASE0) mbase0_q <= cfg_wdata[ADDR_W-1:0];
        if (cfg_addr == RA_MBASE1) mbase1_q <= cfg_wdata[ADDR_W-1:0];
      end
      half_q <= half_hit | (half_q & ~(wr_flags & cfg_wdata[FB_HALF]));
      full_q <= xfer_end | (full_q & ~(wr_flags & cfg_wdata[FB_FULL]));
    end
  end

  always_comb begin
    case (cfg_addr)
      RA_CTRL:   cfg_rdata = 32'({cur_buf, ctrl_q.dbuf, ctrl_q.fie,
                                  ctrl_q.hie, ctrl_q.dir, ctrl_q.en});
      RA_NBYTES: cfg_rdata = 32'(prog_q);
      RA_PADDR:  cfg_rdata = 32'(paddr_q);
      RA_MBASE0: cfg_rdata = 32'(mbase0_q);
      RA_MBASE1: cfg_rdata = 32'(mbase1_q);
      RA_FLAGS:  cfg_rdata = 32'({full_q, half_q});
      RA_REMAIN: cfg_rdata = 32'(rem);
      default:   cfg_rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign prog_cnt = prog_q;
  assign paddr    = paddr_q;
  assign mbase0   = mbase0_q;
  assign mbase1   = mbase1_q;
  assign irq      = (half_q & ctrl_q.hie) | (full_q & ctrl_q.fie);

  AST_END_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !ctrl_q.dbuf && !wr_ctrl) |=> !ctrl_q.en); // R6
  AST_FULL_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> full_q); // R6
  AST_HALF_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && cfg_wdata[FB_HALF] && !half_hit) |=> !half_q); // R10
  AST_PADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && cfg_wr && cfg_addr == RA_PADDR) |=> $stable(paddr_q)); // R4
endmodule

// File: rtl/pdma_xfer_ctrl.sv
`timescale 1ns/1ps
module pdma_xfer_ctrl #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dir,
  input  logic              dbuf,
  input  logic              en_load,
  input  logic [CNT_W-1:0]  prog_cnt,
  input  logic [ADDR_W-1:0] mbase0,
  input  logic [ADDR_W-1:0] mbase1,
  input  logic              tx_empty_req,
  input  logic              rx_full_req,
  input  logic              beat_start,
  input  logic              beat_done,
  output logic [CNT_W-1:0]  rem,
  output logic              cur_buf,
  output logic              beat_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              half_hit,
  output logic              xfer_end,
  output logic              eot
);
  function automatic logic [CNT_W-1:0] half_mark(input logic [CNT_W-1:0] n);
    return n >> 1;
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [CNT_W-1:0]  off);
    return base + ADDR_W'(off);
  endfunction

  logic [CNT_W-1:0] pend_q, rem_q, off_q, rem_next;
  logic             buf_q, eot_q, req_hit, last;

  assign req_hit  = en && (dir ? tx_empty_req : rx_full_req);
  assign last     = (rem_q == CNT_W'(1));
  assign rem_next = rem_q - CNT_W'(1);
  assign xfer_end = beat_done && last;
  assign half_hit = beat_done && (rem_next == half_mark(prog_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      rem_q  <= '0;
      off_q  <= '0;
      buf_q  <= 1'b0;
      eot_q  <= 1'b0;
    end else begin
      eot_q <= xfer_end;
      if (!en || (xfer_end && !dbuf))
        pend_q <= '0;
      else
        pend_q <= pend_q + CNT_W'(req_hit) - CNT_W'(beat_start);
      if (en_load) begin
        rem_q <= prog_cnt;
        off_q <= '0;
        buf_q <= 1'b0;
      end else if (beat_done) begin
        if (last) begin
          rem_q <= dbuf ? prog_cnt : '0;
          off_q <= '0;
          if (dbuf) buf_q <= ~buf_q;
        end else begin
          rem_q <= rem_next;
          off_q <= off_q + CNT_W'(1);
        end
      end
    end
  end

  assign rem        = rem_q;
  assign cur_buf    = buf_q;
  assign eot        = eot_q;
  assign beat_ready = en && (pend_q != '0) && (rem_q != '0);
  assign mem_addr   = beat_addr(buf_q ? mbase1 : mbase0, off_q);

  AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !last && !en_load) |=> rem_q == $past(rem_q) - CNT_W'(1)); // R5
  AST_NO_PEND_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hit && !beat_start) |-> pend_q != '1); // R9
  AST_EOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eot_q |=> !eot_q); // R6
  AST_DBUF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && dbuf && !en_load) |=> (buf_q != $past(buf_q)) && rem_q == prog_cnt); // R8
endmodule

// File: rtl/pdma_beat_fsm.sv
`timescale 1ns/1ps
module pdma_beat_fsm
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              dir,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              m_ack,
  input  logic [DATA_W-1:0] m_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  output logic              beat_start,
  output logic              beat_done
);
  beat_st_e          st_q, st_d;
  logic              dir_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    st_d       = st_q;
    beat_start = 1'b0;
    beat_done  = 1'b0;
    m_req      = 1'b0;
    m_we       = 1'b0;
    m_addr     = '0;
    case (st_q)
      BT_IDLE: begin
        if (go) begin
          st_d       = BT_READ;
          beat_start = 1'b1;
        end
      end
      BT_READ: begin
        m_req  = 1'b1;
        m_addr = dir_q ? mem_addr : paddr;
        if (m_ack) st_d = BT_WRITE;
      end
      BT_WRITE: begin
        m_req  = 1'b1;
        m_we   = 1'b1;
        m_addr = dir_q ? paddr : mem_addr;
        if (m_ack) begin
          st_d      = BT_IDLE;
          beat_done = 1'b1;
        end
      end
      default: st_d = BT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BT_IDLE;
      dir_q  <= 1'b0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (beat_start) dir_q <= dir;
      if (st_q == BT_READ && m_ack) data_q <= m_rdata;
    end
  end

  assign m_wdata = data_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> m_req && $stable(m_addr) && $stable(m_we)); // R12
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    beat_start |=> (m_req && !m_we)); // R12
  AST_GAP_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> !m_req); // R12
endmodule

// File: rtl/pdma_stream.sv
`timescale 1ns/1ps
module pdma_stream
  import pdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              tx_empty_req,
  input  logic              rx_full_req,
  output logic              xfer_end_o,
  output logic              irq,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_ack
);
  ctrl_t             ctrl;
  logic              en_load, cur_buf, half_hit, xfer_end, beat_ready;
  logic              beat_start, beat_done;
  logic [CNT_W-1:0]  prog_cnt, rem;
  logic [ADDR_W-1:0] paddr, mbase0, mbase1, mem_addr;

  pdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rem(rem), .cur_buf(cur_buf), .half_hit(half_hit), .xfer_end(xfer_end),
    .ctrl(ctrl), .en_load(en_load), .prog_cnt(prog_cnt),
    .paddr(paddr), .mbase0(mbase0), .mbase1(mbase1), .irq(irq)
  );

  pdma_xfer_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl.en), .dir(ctrl.dir), .dbuf(ctrl.dbuf), .en_load(en_load),
    .prog_cnt(prog_cnt), .mbase0(mbase0), .mbase1(mbase1),
    .tx_empty_req(tx_empty_req), .rx_full_req(rx_full_req),
    .beat_start(beat_start), .beat_done(beat_done),
    .rem(rem), .cur_buf(cur_buf), .beat_ready(beat_ready), .mem_addr(mem_addr),
    .half_hit(half_hit), .xfer_end(xfer_end), .eot(xfer_end_o)
  );

  pdma_beat_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_beat (
    .clk(clk), .rst_n(rst_n),
    .go(beat_ready), .dir(ctrl.dir), .paddr(paddr), .mem_addr(mem_addr),
    .m_ack(m_ack), .m_rdata(m_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .beat_start(beat_start), .beat_done(beat_done)
  );

  AST_NO_BEAT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    beat_start |-> ctrl.en); // R4
  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.hie && !ctrl.fie) |-> !irq); // R11
endmodule

// File: tb/test_pdma_stream.sv
`timescale 1ns/1ps
module test_pdma_stream;
  import pdma_pkg::*;

  localparam logic [31:0] PER_ADDR = 32'h0000_1000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        tx_req = 1'b0, rx_req = 1'b0;
  logic        xfer_end_o, irq, m_req, m_we;
  logic [31:0] m_addr;
  logic [7:0]  m_wdata;
  logic [7:0]  m_rdata = 8'd0;
  logic        m_ack = 1'b0;

  int tests = 0, fails = 0;
  int tx_n = 0, bus_cnt = 0, eot_cnt = 0, wait_cnt = 0;
  logic [7:0] wmem   [0:255];
  logic [7:0] tx_log [0:255];
  logic [7:0] rx_next = 8'h30;
  logic [7:0] salt = 8'h00;
  int unsigned seed_dummy;

  always #2 clk = ~clk;

  pdma_stream i_pdma_stream (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_empty_req(tx_req), .rx_full_req(rx_req),
    .xfer_end_o(xfer_end_o), .irq(irq),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ack(m_ack)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return (a[7:0] * 8'd13) ^ salt ^ 8'h5a;
  endfunction

  // Bus responder: memory reads return pat(addr), memory writes land in wmem
  always @(negedge clk) begin
    if (m_ack) m_ack = 1'b0;
    else if (m_req) begin
      if (wait_cnt != 0) wait_cnt = wait_cnt - 1;
      else begin
        m_ack = 1'b1;
        bus_cnt = bus_cnt + 1;
        if (m_we) begin
          if (m_addr == PER_ADDR) begin tx_log[tx_n[7:0]] = m_wdata; tx_n = tx_n + 1; end
          else wmem[m_addr[7:0]] = m_wdata;
        end else begin
          if (m_addr == PER_ADDR) begin m_rdata = rx_next; rx_next = rx_next + 8'd1; end
          else m_rdata = pat(m_addr);
        end
        wait_cnt = int'($urandom_range(2, 0));
      end
    end
  end

  always @(posedge clk) if (rst_n && xfer_end_o) eot_cnt <= eot_cnt + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic pulse(input bit tx, input int len);
    @(negedge clk);
    if (tx) tx_req = 1'b1; else rx_req = 1'b1;
    repeat (len) @(negedge clk);
    tx_req = 1'b0; rx_req = 1'b0;
  endtask

  // One full single-buffer transfer, checked byte by byte
  task automatic xfer_check(input bit dir, input int n, input int base, input int gap_max, input bit burst);
    int tx0, e0;
    logic [7:0] rx0;
    logic [31:0] v;
    tx0 = tx_n; e0 = eot_cnt; rx0 = rx_next;
    cfg_write(RA_NBYTES, 32'(n));
    cfg_write(RA_MBASE0, 32'(base));
    cfg_write(RA_CTRL, 32'h1 | (32'(dir) << 1));
    if (burst) pulse(dir, n);
    else for (int k = 0; k < n; k++) begin
      pulse(dir, 1);
      idle(int'($urandom_range(gap_max, 0)));
    end
    idle(20 * n + 40);
    for (int k = 0; k < n; k++) begin
      if (dir) chk("R2 byte to peripheral", 32'(tx_log[(tx0 + k) % 256]), 32'(pat(32'(base + k))));
      else     chk("R3 byte to memory", 32'(wmem[(base + k) % 256]), 32'(8'(rx0 + 8'(k))));
    end
    chk("R6 one end pulse", 32'(eot_cnt - e0), 32'd1);
    cfg_read(RA_CTRL, v);
    chk("R6 run bit cleared", 32'(v[0]), 32'd0);
    cfg_read(RA_REMAIN, v);
    chk("R5 remaining zero", v, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    int b0, e0, t0;
    seed_dummy = $urandom(32'd7331);
    salt = 8'($urandom());
    idle(5);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 m_req", 32'(m_req), 32'd0);
    chk("R1 end pulse", 32'(xfer_end_o), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    cfg_read(RA_CTRL, v);  chk("R1 ctrl", v, 32'd0);
    cfg_read(RA_FLAGS, v); chk("R1 flags", v, 32'd0);

    // R4 requests ignored while not running
    cfg_write(RA_PADDR, PER_ADDR);
    cfg_write(RA_NBYTES, 32'd8);
    cfg_write(RA_MBASE0, 32'h40);
    cfg_write(RA_CTRL, 32'h2);
    b0 = bus_cnt;
    pulse(1'b1, 3); pulse(1'b0, 2);
    idle(20);
    chk("R4 no bus while off", 32'(bus_cnt - b0), 32'd0);
    cfg_read(RA_REMAIN, v); chk("R4 remaining untouched", v, 32'd0);

    // R2/R5/R7/R11 directed memory-to-peripheral, 8 bytes
    t0 = tx_n; e0 = eot_cnt;
    cfg_write(RA_CTRL, 32'hF);
    cfg_read(RA_REMAIN, v); chk("R5 load on enable", v, 32'd8);
    cfg_write(RA_PADDR, 32'h2000);
    cfg_read(RA_PADDR, v); chk("R4 locked while running", v, PER_ADDR);
    b0 = bus_cnt;
    pulse(1'b0, 2); idle(20);
    chk("R2 receive pulses ignored", 32'(bus_cnt - b0), 32'd0);
    for (int k = 0; k < 3; k++) begin pulse(1'b1, 1); idle(20); end
    cfg_read(RA_REMAIN, v); chk("R5 three beats", v, 32'd5);
    cfg_read(RA_FLAGS, v);  chk("R7 half not yet", v, 32'd0);
    pulse(1'b1, 1); idle(20);
    cfg_read(RA_REMAIN, v); chk("R5 four beats", v, 32'd4);
    cfg_read(RA_FLAGS, v);  chk("R7 half at mark", v, 32'd1);
    chk("R11 irq on half", 32'(irq), 32'd1);
    pulse(1'b1, 4); idle(80);   // R9 back-to-back burst
    for (int k = 0; k < 8; k++)
      chk("R2 byte to peripheral", 32'(tx_log[(t0 + k) % 256]), 32'(pat(32'h40 + 32'(k))));
    chk("R6 one end pulse", 32'(eot_cnt - e0), 32'd1);
    cfg_read(RA_CTRL, v);  chk("R6 run bit cleared", 32'(v[0]), 32'd0);
    cfg_read(RA_FLAGS, v); chk("R6 completion flag", v, 32'd3);

    // R10 write-one-to-clear, R11 irq tracking
    cfg_write(RA_FLAGS, 32'h1);
    cfg_read(RA_FLAGS, v); chk("R10 clear half only", v, 32'd2);
    chk("R11 irq from completion", 32'(irq), 32'd1);
    cfg_write(RA_FLAGS, 32'h0);
    cfg_read(RA_FLAGS, v); chk("R10 zero write keeps", v, 32'd2);
    cfg_write(RA_FLAGS, 32'h2);
    cfg_read(RA_FLAGS, v); chk("R10 clear completion", v, 32'd0);
    chk("R11 irq low", 32'(irq), 32'd0);

    // R3 peripheral-to-memory, interrupts disabled
    b0 = bus_cnt;
    cfg_write(RA_NBYTES, 32'd6);
    cfg_write(RA_CTRL, 32'h1);
    pulse(1'b1, 3); idle(20);
    chk("R3 transmit pulses ignored", 32'(bus_cnt - b0), 32'd0);
    cfg_write(RA_CTRL, 32'h0);
    xfer_check(1'b0, 6, 32'h80, 12, 1'b0);
    cfg_read(RA_FLAGS, v); chk("R6 completion flag", 32'(v[FB_FULL]), 32'd1);
    chk("R11 irq masked", 32'(irq), 32'd0);
    cfg_write(RA_FLAGS, 32'h3);

    // R8 ping-pong buffers
    t0 = tx_n; e0 = eot_cnt;
    cfg_write(RA_NBYTES, 32'd4);
    cfg_write(RA_MBASE0, 32'h20);
    cfg_write(RA_MBASE1, 32'h60);
    cfg_write(RA_CTRL, 32'h13);
    for (int k = 0; k < 4; k++) begin pulse(1'b1, 1); idle(3); end
    idle(60);
    cfg_read(RA_CTRL, v);   chk("R8 running on second buffer", v, 32'h33);
    cfg_read(RA_REMAIN, v); chk("R8 count reloaded", v, 32'd4);
    chk("R8 end pulse", 32'(eot_cnt - e0), 32'd1);
    pulse(1'b1, 4); idle(80);
    for (int k = 0; k < 4; k++) begin
      chk("R8 first buffer", 32'(tx_log[(t0 + k) % 256]), 32'(pat(32'h20 + 32'(k))));
      chk("R8 second buffer", 32'(tx_log[(t0 + 4 + k) % 256]), 32'(pat(32'h60 + 32'(k))));
    end
    cfg_read(RA_CTRL, v); chk("R8 back on first buffer", v, 32'h13);
    chk("R8 two end pulses", 32'(eot_cnt - e0), 32'd2);
    cfg_write(RA_CTRL, 32'h0);

    // R9 burst and single-byte corner (half and full together, R7)
    xfer_check(1'b1, 10, 32'hA0, 0, 1'b1);
    cfg_write(RA_FLAGS, 32'h3);
    xfer_check(1'b0, 1, 32'hC0, 0, 1'b0);
    cfg_read(RA_FLAGS, v); chk("R7 half with single byte", v, 32'd3);

    // Constrained random transfers
    for (int r = 0; r < 6; r++) begin
      xfer_check(1'($urandom_range(1, 0)), int'($urandom_range(12, 1)),
                 int'($urandom_range(8'h30, 0)), int'($urandom_range(15, 0)),
                 1'($urandom_range(1, 0)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule